// File: doc/BRIEF.md
# Synchronous Character Receiver with Hunt Mode

This block receives a bit-serial stream on a character-oriented synchronous link. After reset, or after an enter-hunt command, it is in hunt mode. In that mode it shifts every received bit into a window register and tests the window against one or two programmed sync characters. In external mode it skips the comparison and waits for a sync input instead. When hunt ends, a sync-detect status bit is set, and the next bit becomes bit 0 of the first data character.

Characters have 5 to 8 data bits, sent LSB first, and may carry one odd or even parity bit. Each finished character moves into a holding register and raises a ready flag. Reading the data lowers the flag. A character that arrives while the previous one is still unread sets a sticky overrun flag. A parity mismatch sets a sticky parity flag. An error-reset command clears both flags, and a status read clears the sync-detect bit.

Bits count only on cycles where `bit_tick` and `rx_enable` are both high. `bit_tick` is the one-cycle strobe marking a rising edge of the recovered receive clock.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `rx_ready`, `sync_det`, `overrun_err` and `parity_err` are 0 and the receiver is in hunt mode, so no character is delivered before sync is found.
- R2: The mode word `mode_in` has these fields: [1:0] character length code (00=5, 01=6, 10=7, 11=8 bits), [2] parity enable, [3] even parity when 1 and odd when 0, [4] external-sync mode, [5] single sync character. With [5]=1 and [4]=0, hunt ends on the bit where the last L received bits equal the low L bits of sync register A. `sync_det` is 1 after that bit.
- R3: With [5]=0 and [4]=0, hunt ends only when the last 2L bits hold sync A followed at once by sync B. Sync A alone does not end hunt.
- R4: In external-sync mode, a high `ext_sync` while enabled ends hunt and sets `sync_det`. A bit pattern equal to the sync characters does not.
- R5: After hunt ends, assembly begins on the next bit. Data bits arrive LSB first. `rx_char` holds the L data bits with the upper bits zero.
- R6: When parity is enabled, the bit after the data bits is the parity bit. If the parity is wrong, `parity_err` is set and stays set through later good characters.
- R7: `rx_ready` rises in the cycle after a character completes and falls after `rd_data`.
- R8: A character that completes while `rx_ready` is still 1, with no `rd_data` in that cycle, sets `overrun_err`. The new character replaces the old one.
- R9: `cmd_err_reset` clears `overrun_err` and `parity_err`.
- R10: `rd_status` clears `sync_det`, unless hunt exits in the same cycle.
- R11: After hunt ends, sync patterns are delivered as ordinary data. Hunt is entered again only on `cmd_hunt`.
- R12: While `rx_enable` is 0, bit ticks are ignored and no character completes.
- R13: No character completes while the receiver is in hunt mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle strobe: sample `rx_data` now |
| rx_data | input | 1 | Serial data |
| ext_sync | input | 1 | External sync indication |
| rx_enable | input | 1 | Receive enable |
| mode_wr | input | 1 | Load `mode_in` into the mode register |
| mode_in | input | 6 | Mode word (fields in R2) |
| sync_wr_a | input | 1 | Load `sync_in` into sync register A |
| sync_wr_b | input | 1 | Load `sync_in` into sync register B |
| sync_in | input | 8 | Sync character value |
| cmd_hunt | input | 1 | Enter hunt mode |
| cmd_err_reset | input | 1 | Clear error flags |
| rd_data | input | 1 | Data read strobe |
| rd_status | input | 1 | Status read strobe |
| rx_char | output | 8 | Received character |
| rx_ready | output | 1 | Character available |
| sync_det | output | 1 | Sync-detect status |
| overrun_err | output | 1 | Overrun error (sticky) |
| parity_err | output | 1 | Parity error (sticky) |

## Verification
On every cycle, the assertions check how the flags react to internal events:
- a completed character raises ready;
- an unread character turns into overrun;
- hunt exit sets sync-detect;
- reads and error reset clear their flags, and parity stays sticky;
- no character completes during hunt or without an enabled tick.

The assertions cannot show which bit patterns end hunt, whether character framing after hunt is correct, or whether the parity sense and character length are decoded correctly. Those are shown only by the bench's scenarios, which send known bit streams and compare `rx_char` and the flags against values the bench computes itself.

// File: rtl/shrx_pkg.sv
package shrx_pkg;
  localparam int DATA_MAX = 8;
  localparam int SR_W     = 2 * DATA_MAX;
  localparam int CNT_W    = $clog2(SR_W + 1);

  typedef struct packed {
    logic       single_sync;
    logic       ext_mode;
    logic       par_even;
    logic       par_en;
    logic [1:0] len_code;
  } rx_cfg_t;

  // number of data bits for a length code: 5..8
  function automatic logic [3:0] char_bits(logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic [DATA_MAX-1:0] len_mask(logic [1:0] code);
    return {DATA_MAX{1'b1}} >> (2'd3 - code);
  endfunction

  // character in the window: older=0 newest, older=1 the one before it
  function automatic logic [DATA_MAX-1:0] window_char(logic [SR_W-1:0] sr,
                                                      logic [1:0] code, logic older);
    logic [CNT_W-1:0] shift;
    shift = CNT_W'(SR_W) - (older ? {CNT_W'(char_bits(code)) << 1}
                                  : CNT_W'(char_bits(code)));
    return DATA_MAX'(sr >> shift) & len_mask(code);
  endfunction

  function automatic logic parity_fail(logic [DATA_MAX-1:0] data, logic pbit, logic even);
    return (^data) ^ pbit ^ ~even;
  endfunction
endpackage

// File: rtl/shrx_hunt.sv
module shrx_hunt
  import shrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                bit_in,
  input  logic                enable,
  input  logic                enter_hunt,
  input  logic                ext_sync,
  input  logic                ext_mode,
  input  logic                single_sync,
  input  logic [1:0]          len_code,
  input  logic [DATA_MAX-1:0] sync_a,
  input  logic [DATA_MAX-1:0] sync_b,
  output logic                hunting,
  output logic                hunt_exit
);
  logic [SR_W-1:0]  sr, sr_next;
  logic [CNT_W-1:0] fill, fill_next, need;
  logic [DATA_MAX-1:0] msk;
  logic match, filled;

  always_comb begin
    msk       = len_mask(len_code);
    sr_next   = {bit_in, sr[SR_W-1:1]};
    fill_next = (fill == CNT_W'(SR_W)) ? fill : fill + 1'b1;
    need      = single_sync ? CNT_W'(char_bits(len_code))
                            : CNT_W'(char_bits(len_code)) << 1;
    filled    = fill_next >= need;
    if (single_sync)
      match = window_char(sr_next, len_code, 1'b0) == (sync_a & msk);
    else
      match = (window_char(sr_next, len_code, 1'b1) == (sync_a & msk)) &&
              (window_char(sr_next, len_code, 1'b0) == (sync_b & msk));
    hunt_exit = hunting && !enter_hunt &&
                (ext_mode ? (enable && ext_sync) : (tick && filled && match));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunting <= 1'b1;
      sr      <= '0;
      fill    <= '0;
    end else if (enter_hunt) begin
      hunting <= 1'b1;
      sr      <= '0;
      fill    <= '0;
    end else begin
      if (hunting && tick) begin
        sr   <= sr_next;
        fill <= fill_next;
      end
      if (hunt_exit) hunting <= 1'b0;
    end
  end
endmodule

// File: rtl/shrx_frame.sv
module shrx_frame
  import shrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                bit_in,
  input  logic                hunting,
  input  logic [1:0]          len_code,
  input  logic                par_en,
  input  logic                par_even,
  output logic                char_done,
  output logic [DATA_MAX-1:0] char_val,
  output logic                par_bad
);
  logic [3:0] cnt, nbits, last;
  logic [DATA_MAX-1:0] acc, acc_next;
  logic in_par;

  always_comb begin
    nbits    = char_bits(len_code);
    last     = nbits - 4'd1 + {3'b000, par_en};
    in_par   = par_en && (cnt == nbits);
    acc_next = (cnt == 4'd0) ? '0 : acc;
    if (!in_par) acc_next[cnt[2:0]] = bit_in;
    char_done = tick && !hunting && (cnt == last);
    char_val  = acc_next;
    par_bad   = in_par && parity_fail(acc, bit_in, par_even);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (hunting) begin
      cnt <= '0;
    end else if (tick) begin
      acc <= acc_next;
      cnt <= (cnt == last) ? 4'd0 : cnt + 4'd1;
    end
  end
endmodule

// File: rtl/shrx_hold.sv
module shrx_hold
  import shrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                char_done,
  input  logic [DATA_MAX-1:0] char_val,
  input  logic                par_bad,
  input  logic                hunt_exit,
  input  logic                rd_data,
  input  logic                rd_status,
  input  logic                err_reset,
  output logic [DATA_MAX-1:0] rx_char,
  output logic                rx_ready,
  output logic                sync_det,
  output logic                overrun_err,
  output logic                parity_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_char     <= '0;
      rx_ready    <= 1'b0;
      sync_det    <= 1'b0;
      overrun_err <= 1'b0;
      parity_err  <= 1'b0;
    end else begin
      if (char_done) begin
        rx_char  <= char_val;
        rx_ready <= 1'b1;
      end else if (rd_data) begin
        rx_ready <= 1'b0;
      end

      if (char_done && rx_ready && !rd_data) overrun_err <= 1'b1;
      else if (err_reset)                     overrun_err <= 1'b0;

      if (char_done && par_bad) parity_err <= 1'b1;
      else if (err_reset)       parity_err <= 1'b0;

      if (hunt_exit)      sync_det <= 1'b1;
      else if (rd_status) sync_det <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import shrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rx_data,
  input  logic       ext_sync,
  input  logic       rx_enable,
  input  logic       mode_wr,
  input  logic [5:0] mode_in,
  input  logic       sync_wr_a,
  input  logic       sync_wr_b,
  input  logic [7:0] sync_in,
  input  logic       cmd_hunt,
  input  logic       cmd_err_reset,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_char,
  output logic       rx_ready,
  output logic       sync_det,
  output logic       overrun_err,
  output logic       parity_err
);
  rx_cfg_t cfg;
  logic [DATA_MAX-1:0] sync_a, sync_b, char_val;
  logic tick, hunting, hunt_exit, char_done, par_bad;

  assign tick = bit_tick && rx_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      if (mode_wr)   cfg    <= rx_cfg_t'(mode_in);
      if (sync_wr_a) sync_a <= sync_in;
      if (sync_wr_b) sync_b <= sync_in;
    end
  end

  shrx_hunt u_hunt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_in(rx_data), .enable(rx_enable),
    .enter_hunt(cmd_hunt), .ext_sync(ext_sync), .ext_mode(cfg.ext_mode),
    .single_sync(cfg.single_sync), .len_code(cfg.len_code),
    .sync_a(sync_a), .sync_b(sync_b), .hunting(hunting), .hunt_exit(hunt_exit)
  );

  shrx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_in(rx_data), .hunting(hunting),
    .len_code(cfg.len_code), .par_en(cfg.par_en), .par_even(cfg.par_even),
    .char_done(char_done), .char_val(char_val), .par_bad(par_bad)
  );

  shrx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_val(char_val),
    .par_bad(par_bad), .hunt_exit(hunt_exit), .rd_data(rd_data),
    .rd_status(rd_status), .err_reset(cmd_err_reset), .rx_char(rx_char),
    .rx_ready(rx_ready), .sync_det(sync_det), .overrun_err(overrun_err),
    .parity_err(parity_err)
  );
endmodule

// File: rtl/shrx_checker.sv
module shrx_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic rx_enable,
  input logic rd_data,
  input logic rd_status,
  input logic cmd_err_reset,
  input logic rx_ready,
  input logic sync_det,
  input logic overrun_err,
  input logic parity_err,
  input logic char_done,
  input logic hunt_exit,
  input logic hunting
);
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) char_done |=> rx_ready); // R7
  AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) rd_data && !char_done |=> !rx_ready); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) char_done && rx_ready && !rd_data |=> overrun_err); // R8
  AST_ERR_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cmd_err_reset && !char_done |=> !overrun_err && !parity_err); // R9
  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) parity_err && !cmd_err_reset |=> parity_err); // R6
  AST_SYNC_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n) hunt_exit |=> sync_det); // R2
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rd_status && !hunt_exit |=> !sync_det); // R10
  AST_NO_CHAR_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n) hunting |-> !char_done); // R13
  AST_DONE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) char_done |-> bit_tick && rx_enable); // R12
endmodule

bind sync_hunt_rx shrx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_enable(rx_enable),
  .rd_data(rd_data), .rd_status(rd_status), .cmd_err_reset(cmd_err_reset),
  .rx_ready(rx_ready), .sync_det(sync_det), .overrun_err(overrun_err),
  .parity_err(parity_err), .char_done(char_done), .hunt_exit(hunt_exit),
  .hunting(hunting)
);

// File: tb/sync_hunt_rx_test.sv
module sync_hunt_rx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, rx_data = 0, ext_sync = 0, rx_enable = 1;
  logic mode_wr = 0, sync_wr_a = 0, sync_wr_b = 0;
  logic [5:0] mode_in = '0;
  logic [7:0] sync_in = '0;
  logic cmd_hunt = 0, cmd_err_reset = 0, rd_data = 0, rd_status = 0;
  logic [7:0] rx_char;
  logic rx_ready, sync_det, overrun_err, parity_err;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_hunt_rx uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode word: [5] single, [4] external, [3] even, [2] parity on, [1:0] length
  function automatic logic [5:0] mk_mode(logic [1:0] len, logic pen, logic even,
                                         logic ext, logic single);
    return {single, ext, even, pen, len};
  endfunction

  task automatic send_bit(logic b);
    @(negedge clk); rx_data = b; bit_tick = 1;
    @(negedge clk); bit_tick = 0;
  endtask

  task automatic send_char(logic [7:0] v, int n, logic pen, logic even);
    int ones = 0;
    for (int i = 0; i < n; i++) begin
      send_bit(v[i]);
      ones += int'(v[i]);
    end
    if (pen) send_bit(even ? logic'(ones % 2) : logic'((ones + 1) % 2));
  endtask

  task automatic wr_mode(logic [5:0] m);
    @(negedge clk); mode_in = m; mode_wr = 1;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic wr_sync(logic [7:0] a, logic [7:0] b);
    @(negedge clk); sync_in = a; sync_wr_a = 1;
    @(negedge clk); sync_wr_a = 0; sync_in = b; sync_wr_b = 1;
    @(negedge clk); sync_wr_b = 0;
  endtask

  task automatic do_hunt();      @(negedge clk); cmd_hunt = 1;      @(negedge clk); cmd_hunt = 0;      endtask
  task automatic do_rd_data();   @(negedge clk); rd_data = 1;       @(negedge clk); rd_data = 0;       endtask
  task automatic do_rd_status(); @(negedge clk); rd_status = 1;     @(negedge clk); rd_status = 0;     endtask
  task automatic do_err_reset(); @(negedge clk); cmd_err_reset = 1; @(negedge clk); cmd_err_reset = 0; endtask

  task automatic t_reset();
    chk("R1 ready", rx_ready, 0);
    chk("R1 sync_det", sync_det, 0);
    chk("R1 overrun", overrun_err, 0);
    chk("R1 parity", parity_err, 0);
  endtask

  task automatic t_single();
    wr_mode(mk_mode(2'b11, 0, 0, 0, 1));
    wr_sync(8'h16, 8'h00);
    send_char(8'h00, 8, 0, 0);
    chk("R13 no char in hunt", rx_ready, 0);
    chk("R2 no early sync", sync_det, 0);
    send_char(8'h16, 8, 0, 0);
    chk("R2 sync_det set", sync_det, 1);
    chk("R13 sync not delivered", rx_ready, 0);
    do_rd_status();
    chk("R10 status read clears", sync_det, 0);
    send_char(8'hA5, 8, 0, 0);
    chk("R7 ready rises", rx_ready, 1);
    chk("R5 char 8 bit", rx_char, 8'hA5);
    do_rd_data();
    chk("R7 ready falls", rx_ready, 0);
    send_char(8'h16, 8, 0, 0);
    chk("R11 sync as data", rx_char, 8'h16);
    chk("R11 sync_det stays clear", sync_det, 0);
    do_rd_data();
  endtask

  task automatic t_overrun();
    send_char(8'h11, 8, 0, 0);
    chk("R8 no overrun first", overrun_err, 0);
    send_char(8'h22, 8, 0, 0);
    chk("R8 overrun set", overrun_err, 1);
    chk("R8 newest char kept", rx_char, 8'h22);
    do_err_reset();
    chk("R9 overrun cleared", overrun_err, 0);
    do_rd_data();
    chk("R7 ready falls after overrun", rx_ready, 0);
  endtask

  task automatic t_rx_en();
    rx_enable = 0;
    send_char(8'hFF, 8, 0, 0);
    chk("R12 disabled ticks ignored", rx_ready, 0);
    rx_enable = 1;
    send_char(8'h5A, 8, 0, 0);
    chk("R12 framing kept", rx_char, 8'h5A);
    do_rd_data();
  endtask

  task automatic t_len_parity();
    do_hunt();
    wr_mode(mk_mode(2'b00, 1, 1, 0, 1));
    wr_sync(8'h0B, 8'h00);
    send_char(8'h0B, 5, 0, 0);
    chk("R2 5-bit sync found", sync_det, 1);
    do_rd_status();
    send_char(8'h13, 5, 1, 1);
    chk("R5 char 5 bit", rx_char, 8'h13);
    chk("R6 good even parity", parity_err, 0);
    do_rd_data();
    send_bit(0); send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    chk("R6 bad parity flagged", parity_err, 1);
    do_rd_data();
    send_char(8'h04, 5, 1, 1);
    chk("R6 parity sticky", parity_err, 1);
    do_err_reset();
    chk("R9 parity cleared", parity_err, 0);
    do_rd_data();
    wr_mode(mk_mode(2'b10, 1, 0, 0, 1));
    send_char(8'h55, 7, 1, 0);
    chk("R5 char 7 bit", rx_char, 8'h55);
    chk("R6 good odd parity", parity_err, 0);
    do_rd_data();
    wr_mode(mk_mode(2'b01, 0, 0, 0, 1));
    send_char(8'h3F, 6, 0, 0);
    chk("R5 char 6 bit", rx_char, 8'h3F);
    do_rd_data();
  endtask

  task automatic t_dual();
    do_hunt();
    wr_mode(mk_mode(2'b11, 0, 0, 0, 0));
    wr_sync(8'h16, 8'h2D);
    send_char(8'h16, 8, 0, 0);
    chk("R3 first sync alone", sync_det, 0);
    send_char(8'h00, 8, 0, 0);
    send_char(8'h16, 8, 0, 0);
    chk("R3 no pair yet", sync_det, 0);
    send_char(8'h2D, 8, 0, 0);
    chk("R3 pair found", sync_det, 1);
    do_rd_status();
    send_char(8'h81, 8, 0, 0);
    chk("R3 char after pair", rx_char, 8'h81);
    do_rd_data();
  endtask

  task automatic t_ext();
    do_hunt();
    wr_mode(mk_mode(2'b11, 0, 0, 1, 1));
    wr_sync(8'h16, 8'h00);
    send_char(8'h16, 8, 0, 0);
    chk("R4 pattern ignored", sync_det, 0);
    chk("R4 no char before sync", rx_ready, 0);
    @(negedge clk); ext_sync = 1;
    @(negedge clk); ext_sync = 0;
    chk("R4 ext sync sets det", sync_det, 1);
    do_rd_status();
    send_char(8'hC3, 8, 0, 0);
    chk("R4 char after ext sync", rx_char, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_overrun();
    t_rx_en();
    t_len_parity();
    t_dual();
    t_ext();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule